// File: doc/BRIEF.md
# Real-Time Clock With Match Interrupt

This block keeps wall-clock time as an unsigned count of seconds. A one-hertz tick arrives from elsewhere, already synchronised to the system clock, and each pulse advances the count by one. A second register holds an alarm value. When the running count lands on that value, a sticky status flag is set. The flag drives a level interrupt through an enable bit.

Software reaches the block through a small register port, a word-addressed write strobe and a read strobe with registered read data. Through it software sets or reads the time, sets or reads the alarm value, enables the interrupt and acknowledges it.

Two resets reach the block. Power-on reset clears everything. The ordinary system reset clears only the status flag and the read data register. The time, the alarm value and the enable bit survive it, so a warm restart keeps the clock running.

Top module: `rtc_match_top`

## Requirements
- R1: While `por` is high, the time count, the alarm value, the enable bit, the status flag, `rdata` and `irq` all go to zero.
- R2: A pulse on `rst` with `por` low clears the status flag and `rdata`. It leaves the time count, the alarm value and the enable bit unchanged.
- R3: Each system-clock cycle with `tick` high and no time write adds one to the time count. The count wraps from 0xFFFFFFFF to 0.
- R4: A write to address 0 (time) loads `wdata` into the count. The next tick advances the loaded value by one.
- R5: A time write in the same cycle as a tick loads `wdata` without incrementing it. The increment waits for the following tick.
- R6: The count is compared with the alarm value only in the cycle after the count changes, whether by a tick or by a time write. If they are equal, the status flag is set at the end of that cycle.
- R7: Once set, the status flag stays set until a write to address 3 (clear), even after the count moves past the alarm value. If a clear and a new match fall in the same cycle, the flag stays set.
- R8: Writing an alarm value (address 1) equal to the current count does not set the status flag. The flag is set only when the count next changes to that value.
- R9: `irq` equals the status flag ANDed with the enable bit. The enable bit is written through bit 0 at address 2. Reading address 2 returns the enable bit in bit 0 and the status flag in bit 1, and the flag reads back whatever the enable bit's value.
- R10: A read strobe places the addressed register on `rdata` one cycle later. Address 0 returns the time, 1 the alarm value and 2 the control word. Address 3 reads as zero. `rdata` holds its value between reads.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| por | input | 1 | Power-on reset, synchronous, active high |
| rst | input | 1 | Ordinary system reset, synchronous, active high |
| tick | input | 1 | One-cycle pulse per second |
| wr_en | input | 1 | Register write strobe |
| rd_en | input | 1 | Register read strobe |
| addr | input | 2 | Register address: 0 time, 1 alarm, 2 control, 3 clear |
| wdata | input | 32 | Write data |
| rdata | output | 32 | Registered read data |
| irq | output | 1 | Level interrupt |

## Verification
Two results are timed differently:
- **Read data** is due on the clock edge that samples `rd_en`. The scoreboard pops its expected word just after that edge.
- **The interrupt** lags the count. The tick edge updates the count, and the edge after it sets the flag. `irq` is therefore checked only after the second falling edge that follows the tick.

The simultaneous clear-and-match case depends on the same two-edge schedule. The clear write is placed in the cycle between the two edges, so it lands on the edge where the flag is set.

// File: rtl/rtc_pkg.sv
package rtc_pkg;

    localparam int RTC_AW = 2;

    typedef enum logic [RTC_AW-1:0] {
        RA_TIME  = 2'd0,
        RA_ALARM = 2'd1,
        RA_CTRL  = 2'd2,
        RA_CLEAR = 2'd3
    } rtc_addr_e;

    typedef struct packed {
        logic time_we;
        logic alarm_we;
        logic ctrl_we;
        logic clear_we;
    } rtc_wr_t;

    function automatic logic [31:0] ctrl_word(input logic en, input logic st);
        ctrl_word = {30'd0, st, en};
    endfunction

endpackage

// File: rtl/rtc_counter.sv
module rtc_counter #(
    parameter int TW = 32
) (
    input  logic          clk,
    input  logic          por,
    input  logic          ld,
    input  logic [TW-1:0] ld_val,
    input  logic          tick,
    output logic [TW-1:0] cnt_q,
    output logic          upd_q
);
    localparam logic [TW-1:0] ONE = TW'(1);

    always_ff @(posedge clk) begin
        if (por) begin
            cnt_q <= '0;
            upd_q <= 1'b0;
        end else begin
            upd_q <= ld | tick;
            if (ld)
                cnt_q <= ld_val;
            else if (tick)
                cnt_q <= cnt_q + ONE;
        end
    end
endmodule

// File: rtl/rtc_alarm.sv
module rtc_alarm #(
    parameter int TW = 32
) (
    input  logic          clk,
    input  logic          por,
    input  logic          rst,
    input  logic          alarm_we,
    input  logic          ctrl_we,
    input  logic          clear_we,
    input  logic [TW-1:0] wdata,
    input  logic [TW-1:0] cnt,
    input  logic          upd,
    output logic [TW-1:0] alarm_q,
    output logic          en_q,
    output logic          stat_q
);
    logic hit;

    assign hit = upd && (cnt == alarm_q);

    always_ff @(posedge clk) begin
        if (por) begin
            alarm_q <= '0;
            en_q    <= 1'b0;
        end else begin
            if (alarm_we) alarm_q <= wdata;
            if (ctrl_we)  en_q    <= wdata[0];
        end
    end

    always_ff @(posedge clk) begin
        if (por || rst)
            stat_q <= 1'b0;
        else if (hit)
            stat_q <= 1'b1;
        else if (clear_we)
            stat_q <= 1'b0;
    end
endmodule

// File: rtl/rtc_regif.sv
module rtc_regif #(
    parameter int TW = 32
) (
    input  logic                  clk,
    input  logic                  por,
    input  logic                  rst,
    input  logic                  wr_en,
    input  logic                  rd_en,
    input  logic [rtc_pkg::RTC_AW-1:0] addr,
    input  logic [TW-1:0]         time_q,
    input  logic [TW-1:0]         alarm_q,
    input  logic                  en_q,
    input  logic                  stat_q,
    output rtc_pkg::rtc_wr_t      wr,
    output logic [TW-1:0]         rdata
);
    import rtc_pkg::*;

    rtc_addr_e    sel;
    logic [TW-1:0] rmux;

    assign sel = rtc_addr_e'(addr);

    always_comb begin
        wr.time_we  = wr_en && (sel == RA_TIME);
        wr.alarm_we = wr_en && (sel == RA_ALARM);
        wr.ctrl_we  = wr_en && (sel == RA_CTRL);
        wr.clear_we = wr_en && (sel == RA_CLEAR);
    end

    always_comb begin
        case (sel)
            RA_TIME:  rmux = time_q;
            RA_ALARM: rmux = alarm_q;
            RA_CTRL:  rmux = TW'(ctrl_word(en_q, stat_q));
            default:  rmux = '0;
        endcase
    end

    always_ff @(posedge clk) begin
        if (por || rst)
            rdata <= '0;
        else if (rd_en)
            rdata <= rmux;
    end
endmodule

// File: rtl/rtc_match_top.sv
module rtc_match_top #(
    parameter int TW = 32
) (
    input  logic          clk,
    input  logic          por,
    input  logic          rst,
    input  logic          tick,
    input  logic          wr_en,
    input  logic          rd_en,
    input  logic [1:0]    addr,
    input  logic [TW-1:0] wdata,
    output logic [TW-1:0] rdata,
    output logic          irq
);
    rtc_pkg::rtc_wr_t wr;
    logic [TW-1:0]    time_q;
    logic [TW-1:0]    alarm_q;
    logic             upd_q;
    logic             en_q;
    logic             stat_q;

    rtc_regif #(.TW(TW)) u_regif (
        .clk(clk), .por(por), .rst(rst), .wr_en(wr_en), .rd_en(rd_en),
        .addr(addr), .time_q(time_q), .alarm_q(alarm_q), .en_q(en_q),
        .stat_q(stat_q), .wr(wr), .rdata(rdata)
    );

    rtc_counter #(.TW(TW)) u_cnt (
        .clk(clk), .por(por), .ld(wr.time_we), .ld_val(wdata),
        .tick(tick), .cnt_q(time_q), .upd_q(upd_q)
    );

    rtc_alarm #(.TW(TW)) u_alarm (
        .clk(clk), .por(por), .rst(rst), .alarm_we(wr.alarm_we),
        .ctrl_we(wr.ctrl_we), .clear_we(wr.clear_we), .wdata(wdata),
        .cnt(time_q), .upd(upd_q), .alarm_q(alarm_q), .en_q(en_q),
        .stat_q(stat_q)
    );

    assign irq = stat_q & en_q;
endmodule

// File: rtl/rtc_match_chk.sv
module rtc_match_chk #(
    parameter int TW = 32
) (
    input logic          clk,
    input logic          por,
    input logic          rst,
    input logic          tick,
    input logic          wr_en,
    input logic [1:0]    addr,
    input logic [TW-1:0] wdata,
    input logic          irq,
    input logic [TW-1:0] time_q,
    input logic [TW-1:0] alarm_q,
    input logic          en_q,
    input logic          stat_q
);
    logic time_wr, clr_wr, alarm_wr, ctrl_wr;
    assign time_wr  = wr_en && addr == 2'd0;
    assign alarm_wr = wr_en && addr == 2'd1;
    assign ctrl_wr  = wr_en && addr == 2'd2;
    assign clr_wr   = wr_en && addr == 2'd3;

    // R3
    tick_inc_chk: assert property (@(posedge clk) disable iff (por)
        tick && !time_wr |=> time_q == $past(time_q) + TW'(1));

    // R4
    time_load_chk: assert property (@(posedge clk) disable iff (por)
        time_wr |=> time_q == $past(wdata));

    // R2
    sysrst_keep_chk: assert property (@(posedge clk) disable iff (por)
        rst && !tick && !time_wr && !alarm_wr && !ctrl_wr
        |=> $stable(time_q) && $stable(alarm_q) && $stable(en_q));

    // R7
    stat_hold_chk: assert property (@(posedge clk) disable iff (por)
        stat_q && !clr_wr && !rst |=> stat_q);

    // R9
    irq_gate_chk: assert property (@(posedge clk) disable iff (por)
        !en_q |-> !irq);

    // R1
    por_clear_chk: assert property (@(posedge clk)
        por |=> time_q == '0 && alarm_q == '0 && !en_q && !stat_q);
endmodule

bind rtc_match_top rtc_match_chk #(.TW(TW)) u_chk (
    .clk(clk), .por(por), .rst(rst), .tick(tick), .wr_en(wr_en),
    .addr(addr), .wdata(wdata), .irq(irq), .time_q(time_q),
    .alarm_q(alarm_q), .en_q(en_q), .stat_q(stat_q)
);

// File: tb/sim_rtc_match_top.sv
`timescale 1ns/1ps
module sim_rtc_match_top;
    logic        clk = 1'b0;
    logic        por = 1'b1;
    logic        rst = 1'b0;
    logic        tick = 1'b0;
    logic        wr_en = 1'b0;
    logic        rd_en = 1'b0;
    logic [1:0]  addr = 2'd0;
    logic [31:0] wdata = '0;
    logic [31:0] rdata;
    logic        irq;

    int total = 0;
    int bad = 0;
    bit done = 0;

    logic [31:0] exp_q[$];
    string       tag_q[$];

    always #2 clk = ~clk;

    rtc_match_top u0 (
        .clk(clk), .por(por), .rst(rst), .tick(tick), .wr_en(wr_en),
        .rd_en(rd_en), .addr(addr), .wdata(wdata), .rdata(rdata), .irq(irq)
    );

    // monitor: pops an expected word the edge a read is sampled
    always @(posedge clk) begin
        logic rd_seen;
        rd_seen = rd_en;
        #1;
        if (rd_seen && exp_q.size() > 0) begin
            logic [31:0] e;
            string t;
            e = exp_q.pop_front();
            t = tag_q.pop_front();
            total++;
            if (rdata !== e) begin
                bad++;
                $display("FAIL %s: rdata=%h expected=%h", t, rdata, e);
            end
        end
    end

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    task automatic wr_reg(input logic [1:0] a, input logic [31:0] d);
        @(negedge clk);
        wr_en = 1'b1; addr = a; wdata = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic rd_chk(input logic [1:0] a, input logic [31:0] e, input string t);
        @(negedge clk);
        exp_q.push_back(e);
        tag_q.push_back(t);
        rd_en = 1'b1; addr = a;
        @(negedge clk);
        rd_en = 1'b0;
    endtask

    task automatic pulse_tick();
        @(negedge clk);
        tick = 1'b1;
        @(negedge clk);
        tick = 1'b0;
    endtask

    task automatic irq_chk(input logic e, input string t);
        total++;
        if (irq !== e) begin
            bad++;
            $display("FAIL %s: irq=%b expected=%b", t, irq, e);
        end
    endtask

    initial begin
        idle(3);
        // R1: power-on state
        irq_chk(1'b0, "R1 irq during por");
        por = 1'b0;
        rd_chk(2'd0, 32'd0, "R1 time after por");
        rd_chk(2'd1, 32'd0, "R1 alarm after por");
        rd_chk(2'd2, 32'd0, "R1 ctrl after por");

        // R4: load then advance
        wr_reg(2'd0, 32'd1000);
        rd_chk(2'd0, 32'd1000, "R4 loaded time");
        pulse_tick();
        rd_chk(2'd0, 32'd1001, "R4 time after tick");

        // R3: several ticks and wrap
        pulse_tick(); pulse_tick(); pulse_tick();
        rd_chk(2'd0, 32'd1004, "R3 three ticks");
        wr_reg(2'd1, 32'h0000_5555);
        wr_reg(2'd0, 32'hFFFF_FFFF);
        pulse_tick();
        rd_chk(2'd0, 32'd0, "R3 wrap to zero");

        // R5: write coincident with tick
        @(negedge clk);
        wr_en = 1'b1; addr = 2'd0; wdata = 32'd500; tick = 1'b1;
        @(negedge clk);
        wr_en = 1'b0; tick = 1'b0;
        rd_chk(2'd0, 32'd500, "R5 write wins over tick");
        pulse_tick();
        rd_chk(2'd0, 32'd501, "R5 next tick increments");

        // R10: address 3 reads zero, rdata holds
        rd_chk(2'd3, 32'd0, "R10 clear addr reads zero");
        rd_chk(2'd1, 32'h0000_5555, "R10 alarm readback");
        idle(2);
        total++;
        if (rdata !== 32'h0000_5555) begin
            bad++;
            $display("FAIL R10 hold: rdata=%h expected=%h", rdata, 32'h5555);
        end

        // R8: alarm equal to current count does not fire
        wr_reg(2'd1, 32'd501);
        idle(3);
        rd_chk(2'd2, 32'd0, "R8 no status on alarm write");

        // R6/R9: match while disabled, status still readable
        wr_reg(2'd1, 32'd503);
        pulse_tick();
        irq_chk(1'b0, "R6 no early match");
        pulse_tick();
        idle(1);
        irq_chk(1'b0, "R9 irq masked while disabled");
        rd_chk(2'd2, 32'h2, "R6 status set at match");
        wr_reg(2'd2, 32'd1);
        irq_chk(1'b1, "R9 irq after enable");

        // R7: stays set after count moves on
        pulse_tick(); pulse_tick();
        idle(1);
        irq_chk(1'b1, "R7 held past match");
        wr_reg(2'd3, 32'd0);
        irq_chk(1'b0, "R7 cleared by write");

        // R6: time write equal to alarm fires
        wr_reg(2'd0, 32'd503);
        idle(1);
        irq_chk(1'b1, "R6 time write hits alarm");
        wr_reg(2'd3, 32'd0);

        // R7: clear in the same cycle as a new match, set wins
        wr_reg(2'd0, 32'd502);
        wr_reg(2'd3, 32'd0);
        irq_chk(1'b0, "R7 clear before race");
        @(negedge clk);
        tick = 1'b1;
        @(negedge clk);
        tick = 1'b0; wr_en = 1'b1; addr = 2'd3;
        @(negedge clk);
        wr_en = 1'b0;
        irq_chk(1'b1, "R7 match beats clear");

        // R2: system reset
        rst = 1'b1;
        @(negedge clk);
        rst = 1'b0;
        irq_chk(1'b0, "R2 status cleared by rst");
        rd_chk(2'd0, 32'd503, "R2 time kept");
        rd_chk(2'd1, 32'd503, "R2 alarm kept");
        rd_chk(2'd2, 32'd1, "R2 enable kept, status clear");

        // R1: power-on reset again clears all
        por = 1'b1;
        idle(2);
        por = 1'b0;
        rd_chk(2'd0, 32'd0, "R1 time cleared by por");
        rd_chk(2'd2, 32'd0, "R1 ctrl cleared by por");
        idle(2);

        done = 1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        #(200000 * 4);
        if (!done) begin
            total++;
            bad++;
            $display("FAIL watchdog: finished=0 expected=1");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end
endmodule